// File: doc/BRIEF.md
# Hybrid Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two predictors run side by side. The first is a table of 2-bit saturating counters addressed by a shift register that holds the outcomes of the most recent branches. The second is a two-level local predictor. Its first level keeps a short outcome history for each branch, selected by PC bits. Its second level is a table of 3-bit saturating counters addressed by that history. A third table of 2-bit counters, addressed by the global history, decides which of the two predictors the final answer comes from.

A lookup is purely combinational. The fetch stage presents a PC and, in the same cycle, receives the final direction, both sub-predictions and the table indices that were used. The pipeline keeps those values with the branch. When the branch resolves, it returns them with the real outcome on the update port. That port trains the counters and shifts the outcome into the global history and into the branch's local history. At the default sizes the block holds 4K+4K two-bit counters, 1K ten-bit histories and 1K three-bit counters, 29K bits in all.

Top module: `hybrid_dir_predictor`

## Requirements
- R1: `pred_taken` equals `pred_global` when the selector counter read at the current global history has its MSB set, and equals `pred_local` otherwise. When the two sub-predictions agree, `pred_taken` equals both.
- R2: The global counter is read at the address given by the global history. `pred_global` is 1 exactly when that 2-bit counter has its MSB set (value 2 or 3).
- R3: `pred_gidx` shows the global history. Each valid update shifts it left by one and places `upd_taken` in bit 0, so bit i holds the outcome of the i-th most recent update, with i = 0 the newest.
- R4: The local history entry is selected by `lookup_pc[11:2]`, and this index is shown on `pred_lidx`. A valid update shifts `upd_taken` into bit 0 of entry `upd_lidx`.
- R5: The 10-bit local history (`pred_lhist`) addresses the 3-bit counter table. `pred_local` is 1 exactly when that counter is 4 or more.
- R6: Every counter saturates. A 2-bit counter stays at 3 when it is moved up and at 0 when it is moved down. A 3-bit counter stays at 7 and at 0 in the same way.
- R7: The selector counter at `upd_gidx` is trained only when `upd_global` differs from `upd_local`. It moves up (toward choosing global) when `upd_global` equals `upd_taken`, and down otherwise.
- R8: A valid update moves the global counter at `upd_gidx` and the local counter at `upd_lhist` one step toward `upd_taken`.
- R9: While `upd_valid` is 0, the update fields have no effect: the predictions and indices for every PC stay the same.
- R10: After reset, every 2-bit counter is 1, every 3-bit counter is 3 and every history is zero. The first lookup therefore predicts not taken from both sides and selects the local side.
- R11: A lookup answers in the same cycle as its PC. A valid update becomes visible to lookups from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_pc | input | PC_W | PC of the branch being fetched |
| pred_taken | output | 1 | Final predicted direction |
| pred_global | output | 1 | Global-side prediction |
| pred_local | output | 1 | Local-side prediction |
| pred_gidx | output | GHIST_W | Global history used as the index for the global and selector tables |
| pred_lidx | output | LTAB_AW | Local history table index taken from the PC |
| pred_lhist | output | LHIST_W | Local history read, used as the index for the local counters |
| upd_valid | input | 1 | Update strobe |
| upd_taken | input | 1 | Resolved outcome |
| upd_global | input | 1 | Saved global-side prediction |
| upd_local | input | 1 | Saved local-side prediction |
| upd_gidx | input | GHIST_W | Saved global history index |
| upd_lidx | input | LTAB_AW | Saved local history table index |
| upd_lhist | input | LHIST_W | Saved local history |

## Verification
The bench drives counters into both rails. A table that wraps instead of saturating would flip a strongly taken entry to not taken after one more taken outcome. A loop branch with a period of four checks that the local history fills from bit 0 and is selected by the right PC bits; a reversed shift or an off-by-one slice would read the wrong 3-bit counter. Mixed branches make the two sides disagree, which tests selector training: a design that trains on agreement, or moves the wrong way, would choose the wrong side. Cycles with the strobe low and garbage on the update fields come last; any leaked write would show up as a changed prediction.

// File: rtl/bp_pkg.sv
package bp_pkg;
  // Which side the selector counter points at.
  typedef enum logic {
    PICK_LOCAL  = 1'b0,
    PICK_GLOBAL = 1'b1
  } pick_e;

  // The selector MSB names the side to use.
  function automatic pick_e chooser_pick(input logic sel_msb);
    return sel_msb ? PICK_GLOBAL : PICK_LOCAL;
  endfunction

  // A history register takes the new outcome in at bit 0.
  function automatic logic [31:0] hist_push(input logic [31:0] h, input logic bit_in);
    return {h[30:0], bit_in};
  endfunction
endpackage

// File: rtl/sat_ctr_table.sv
module sat_ctr_table #(
  parameter int AW = 12,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_idx,
  output logic          rd_taken,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_idx,
  input  logic          upd_up
);
  localparam int N = 1 << AW;
  localparam logic [CW-1:0] CMAX    = '1;
  localparam logic [CW-1:0] CMIN    = '0;
  localparam logic [CW-1:0] WEAK_NT = {1'b0, {(CW-1){1'b1}}};

  logic [CW-1:0] mem [N];
  logic [CW-1:0] upd_cur;
  logic [CW-1:0] upd_nxt;

  function automatic logic [CW-1:0] sat_step(input logic [CW-1:0] c, input logic up);
    if (up) return (c == CMAX) ? c : c + 1'b1;
    else    return (c == CMIN) ? c : c - 1'b1;
  endfunction

  assign upd_cur  = mem[upd_idx];
  assign upd_nxt  = sat_step(upd_cur, upd_up);
  assign rd_taken = mem[rd_idx][CW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= WEAK_NT;
    end else if (upd_en) begin
      mem[upd_idx] <= upd_nxt;
    end
  end

  a_r6_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_up && upd_cur == CMAX) |=> mem[$past(upd_idx)] == CMAX);

  a_r6_hold_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_up && upd_cur == CMIN) |=> mem[$past(upd_idx)] == CMIN);

  a_r8_moves_toward: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_up && upd_cur != CMAX) |=> mem[$past(upd_idx)] > $past(upd_cur));
endmodule

// File: rtl/local_hist_table.sv
module local_hist_table
  import bp_pkg::*;
#(
  parameter int AW = 10,
  parameter int HW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_idx,
  output logic [HW-1:0] rd_hist,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_idx,
  input  logic          upd_bit
);
  localparam int N = 1 << AW;

  logic [HW-1:0] mem [N];
  logic [HW-1:0] upd_cur;
  logic [HW-1:0] upd_nxt;
  logic [31:0]   pushed;

  assign upd_cur = mem[upd_idx];
  assign pushed  = hist_push(32'(upd_cur), upd_bit);
  assign upd_nxt = pushed[HW-1:0];
  assign rd_hist = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (upd_en) begin
      mem[upd_idx] <= upd_nxt;
    end
  end

  a_r4_newest_at_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> mem[$past(upd_idx)][0] == $past(upd_bit));

  a_r4_older_moves_up: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> mem[$past(upd_idx)][HW-1:1] == $past(upd_cur[HW-2:0]));
endmodule

// File: rtl/hybrid_dir_predictor.sv
module hybrid_dir_predictor
  import bp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int GHIST_W = 12,
  parameter int LTAB_AW = 10,
  parameter int LHIST_W = 10,
  parameter int GCNT_W  = 2,
  parameter int LCNT_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PC_W-1:0]    lookup_pc,
  output logic               pred_taken,
  output logic               pred_global,
  output logic               pred_local,
  output logic [GHIST_W-1:0] pred_gidx,
  output logic [LTAB_AW-1:0] pred_lidx,
  output logic [LHIST_W-1:0] pred_lhist,
  input  logic               upd_valid,
  input  logic               upd_taken,
  input  logic               upd_global,
  input  logic               upd_local,
  input  logic [GHIST_W-1:0] upd_gidx,
  input  logic [LTAB_AW-1:0] upd_lidx,
  input  logic [LHIST_W-1:0] upd_lhist
);
  localparam int PC_LO = 2;
  localparam int PC_HI = PC_LO + LTAB_AW - 1;

  logic [GHIST_W-1:0] ghist;
  logic [31:0]        ghist_pushed;
  logic               sel_msb;
  pick_e              pick;
  logic               sel_train;
  logic               sel_toward_global;

  // Named events for the assertions.
  assign sel_train         = upd_valid && (upd_global != upd_local);
  assign sel_toward_global = (upd_global == upd_taken);
  assign ghist_pushed      = hist_push(32'(ghist), upd_taken);

  assign pred_lidx = lookup_pc[PC_HI:PC_LO];
  assign pred_gidx = ghist;

  local_hist_table #(.AW(LTAB_AW), .HW(LHIST_W)) u_lht (
    .clk, .rst_n,
    .rd_idx (pred_lidx), .rd_hist(pred_lhist),
    .upd_en (upd_valid), .upd_idx(upd_lidx), .upd_bit(upd_taken)
  );

  sat_ctr_table #(.AW(GHIST_W), .CW(GCNT_W)) u_gtab (
    .clk, .rst_n,
    .rd_idx (ghist), .rd_taken(pred_global),
    .upd_en (upd_valid), .upd_idx(upd_gidx), .upd_up(upd_taken)
  );

  sat_ctr_table #(.AW(LHIST_W), .CW(LCNT_W)) u_ltab (
    .clk, .rst_n,
    .rd_idx (pred_lhist), .rd_taken(pred_local),
    .upd_en (upd_valid), .upd_idx(upd_lhist), .upd_up(upd_taken)
  );

  sat_ctr_table #(.AW(GHIST_W), .CW(GCNT_W)) u_sel (
    .clk, .rst_n,
    .rd_idx (ghist), .rd_taken(sel_msb),
    .upd_en (sel_train), .upd_idx(upd_gidx), .upd_up(sel_toward_global)
  );

  assign pick       = chooser_pick(sel_msb);
  assign pred_taken = (pick == PICK_GLOBAL) ? pred_global : pred_local;

  always_ff @(posedge clk) begin
    if (!rst_n)         ghist <= '0;
    else if (upd_valid) ghist <= ghist_pushed[GHIST_W-1:0];
  end

  a_r3_ghist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> pred_gidx == {$past(pred_gidx[GHIST_W-2:0]), $past(upd_taken)});

  a_r9_ghist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(pred_gidx));

  a_r1_agree_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_global == pred_local) |-> pred_taken == pred_global);

  a_r7_no_train_on_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_global == upd_local) |-> !sel_train);
endmodule

// File: tb/hybrid_dir_predictor_tb.sv
module hybrid_dir_predictor_tb;
  localparam int CLK_P = 10;
  localparam int GW = 12, LAW = 10, LHW = 10;

  logic           clk = 0, rst_n = 0;
  logic [31:0]    lookup_pc = '0;
  logic           pred_taken, pred_global, pred_local;
  logic [GW-1:0]  pred_gidx;
  logic [LAW-1:0] pred_lidx;
  logic [LHW-1:0] pred_lhist;
  logic           upd_valid = 0, upd_taken = 0, upd_global = 0, upd_local = 0;
  logic [GW-1:0]  upd_gidx = '0;
  logic [LAW-1:0] upd_lidx = '0;
  logic [LHW-1:0] upd_lhist = '0;

  always #(CLK_P/2) clk = ~clk;

  hybrid_dir_predictor u_dut (
    .clk, .rst_n, .lookup_pc, .pred_taken, .pred_global, .pred_local,
    .pred_gidx, .pred_lidx, .pred_lhist, .upd_valid, .upd_taken,
    .upd_global, .upd_local, .upd_gidx, .upd_lidx, .upd_lhist
  );

  // Behavioral reference: counters as integers clamped into their range.
  int m_glb [1<<GW];
  int m_sel [1<<GW];
  int m_lht [1<<LAW];
  int m_loc [1<<LHW];
  int m_gh;

  typedef struct {
    int t, g, l, gi, li, lh;
    string tag;
  } exp_t;
  exp_t q[$];
  event drv_ev;
  int n_chk = 0, n_bad = 0;
  int lfsr = 16'hACE1;

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic chk(string tag, string fld, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, fld, act, exp);
    end
  endtask

  function automatic int next_rand();
    lfsr = ((lfsr >> 1) | ((((lfsr >> 0) ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 16'hFFFF;
    return lfsr;
  endfunction

  // Driver: one branch per cycle, lookup and its own update in that cycle.
  task automatic step(input int pc, input bit taken, input bit valid, input string tag);
    exp_t e;
    int li, lh, eg, el, us;
    @(negedge clk);
    li = (pc >> 2) % (1 << LAW);
    lh = m_lht[li];
    eg = (m_glb[m_gh] >= 2) ? 1 : 0;
    el = (m_loc[lh] >= 4) ? 1 : 0;
    us = (m_sel[m_gh] >= 2) ? 1 : 0;
    e.t = us ? eg : el; e.g = eg; e.l = el;
    e.gi = m_gh; e.li = li; e.lh = lh; e.tag = tag;
    lookup_pc = pc;
    upd_valid = valid;
    if (valid) begin
      upd_taken = taken; upd_global = eg[0]; upd_local = el[0];
      upd_gidx = GW'(m_gh); upd_lidx = LAW'(li); upd_lhist = LHW'(lh);
    end else begin
      upd_taken = next_rand() % 2; upd_global = next_rand() % 2;
      upd_local = next_rand() % 2; upd_gidx = GW'(next_rand());
      upd_lidx = LAW'(next_rand()); upd_lhist = LHW'(next_rand());
    end
    q.push_back(e);
    ->drv_ev;
    if (valid) begin
      m_glb[m_gh] = clampi(m_glb[m_gh] + (taken ? 1 : -1), 0, 3);
      m_loc[lh]   = clampi(m_loc[lh] + (taken ? 1 : -1), 0, 7);
      if (eg != el)
        m_sel[m_gh] = clampi(m_sel[m_gh] + ((eg == int'(taken)) ? 1 : -1), 0, 3);
      m_gh     = ((m_gh << 1) | int'(taken)) % (1 << GW);
      m_lht[li] = ((lh << 1) | int'(taken)) % (1 << LHW);
    end
  endtask

  // Monitor: compares the same-cycle answer before the next rising edge.
  initial begin
    exp_t e;
    forever begin
      @(drv_ev);
      #1;
      e = q.pop_front();
      chk(e.tag, "pred_taken",  int'(pred_taken),  e.t);
      chk(e.tag, "pred_global", int'(pred_global), e.g);
      chk(e.tag, "pred_local",  int'(pred_local),  e.l);
      chk(e.tag, "pred_gidx",   int'(pred_gidx),   e.gi);
      chk(e.tag, "pred_lidx",   int'(pred_lidx),   e.li);
      chk(e.tag, "pred_lhist",  int'(pred_lhist),  e.lh);
    end
  end

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << GW); i++) begin m_glb[i] = 1; m_sel[i] = 1; end
    for (int i = 0; i < (1 << LAW); i++) m_lht[i] = 0;
    for (int i = 0; i < (1 << LHW); i++) m_loc[i] = 3;
    m_gh = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10: reset state against literal values.
    @(negedge clk);
    lookup_pc = 32'h0000_1234;
    #1;
    chk("R10", "pred_taken",  int'(pred_taken), 0);
    chk("R10", "pred_global", int'(pred_global), 0);
    chk("R10", "pred_local",  int'(pred_local), 0);
    chk("R10", "pred_gidx",   int'(pred_gidx), 0);
    chk("R10", "pred_lhist",  int'(pred_lhist), 0);
    chk("R4",  "pred_lidx",   int'(pred_lidx), 'h08D);

    // R2 R8 R11: always-taken branch, next-cycle visibility.
    for (int i = 0; i < 8; i++) step('h400, 1'b1, 1'b1, "R2_R8_R11");
    // R3 R4 R5: period-4 loop branch, local history learns it.
    for (int i = 0; i < 120; i++) step('h2F0, (i % 4) != 3, 1'b1, "R3_R4_R5");
    // R6: push counters into the top rail, then one not-taken.
    for (int i = 0; i < 24; i++) step('h8A4, 1'b1, 1'b1, "R6_top");
    step('h8A4, 1'b0, 1'b1, "R6_top_exit");
    for (int i = 0; i < 24; i++) step('h8A4, 1'b0, 1'b1, "R6_floor");
    step('h8A4, 1'b1, 1'b1, "R6_floor_exit");
    // R1 R7: mixed branches so the two sides disagree.
    for (int i = 0; i < 600; i++) begin
      int pc;
      bit t;
      pc = 'h1000 + ((i % 6) << 2);
      case (i % 6)
        0: t = 1'b1;
        1: t = (i % 12) < 6;
        2: t = next_rand() % 2;
        3: t = ((i / 6) % 3) != 0;
        4: t = 1'b0;
        default: t = (i % 12) >= 6;
      endcase
      step(pc, t, 1'b1, "R1_R7");
    end
    // R9: strobe low with garbage on every update field.
    for (int i = 0; i < 12; i++) step('h1000 + ((i % 6) << 2), 1'b1, 1'b0, "R9_ignored");
    for (int i = 0; i < 6; i++) step('h1000 + (i << 2), 1'b0, 1'b1, "R9_after");

    @(negedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule